// File: doc/BRIEF.md
# Packing Capture FIFO for Audio Samples

The block sits between a microphone front end and a host reader. Each cycle the front end may offer one stereo sample: a left and a right value, 24 bits wide, qualified by a valid strobe. A packer turns these samples into 32-bit words according to one of four layouts, and the words go into a 128-word first-in first-out store. The host takes words from a read port that shows the oldest word at all times. A pop strobe advances the port to the next word.

A word-count threshold drives an interrupt, a wake request and a pair of DMA request lines. A select bit chooses which of the two DMA request lines carries the threshold event. A not-empty flag and a sticky overrun flag are also reported. Each interrupt source has its own enable bit. The block holds itself flushed while the run input is low, so it accepts nothing until software raises that input.

Top module: `cap_pack_fifo`

## Requirements
- R1: While `run_i` is 0, and after reset, the store holds no words: `level_o` is 0 and `not_empty_o` is 0. Samples offered while `run_i` is 0 are ignored.
- R2: `mode_i`=0 (mono 16-bit) packs two consecutive left samples into one word. The first sample goes in bits 15:0 and the second in bits 31:16. Bits 23:16 of each input and the whole right input are ignored.
- R3: `mode_i`=1 (stereo 16-bit) writes one word per sample. The word holds left[15:0] in bits 15:0 and right[15:0] in bits 31:16.
- R4: `mode_i`=2 (mono 24-bit) writes one word per sample: the left value in bits 23:0, with bit 23 copied into bits 31:24.
- R5: `mode_i`=3 (stereo 24-bit) writes two words per sample, both sign-extended as in R4: the left word first, then the right word.
- R6: `rd_data_o` shows the oldest stored word. `rd_pop_i` removes it when the store is not empty and is ignored when the store is empty.
- R7: Threshold code 0 means 1 word. Any other code c means 2*c words. The threshold is reached when `level_o` is at least that count.
- R8: When the threshold is reached, `thr_irq_o` follows enable bit 1 and `thr_wake_o` follows enable bit 2. The event drives `dreq_dflt_o` when `dreq_sel_i`=0 and `dreq_fifo_o` when `dreq_sel_i`=1.
- R9: A word that arrives with the store full is dropped and sets `ovr_o`. The flag stays set until a pulse on `ovr_clr_i` (or `run_i`=0) clears it. The stored words are left unchanged.
- R10: `irq_o` is the OR of three terms: not-empty AND enable bit 0, threshold reached AND enable bit 1, overrun AND enable bit 3.
- R11: A mono 16-bit half word that is waiting for its partner is discarded when `run_i` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = operational, 0 = store held flushed |
| mode_i | input | 2 | Packing layout, 0..3 |
| thr_code_i | input | 6 | Threshold code |
| ien_i | input | 4 | Enables: 0 not-empty, 1 threshold interrupt, 2 wake, 3 overrun |
| dreq_sel_i | input | 1 | DMA request line select |
| ovr_clr_i | input | 1 | Clear pulse for the overrun flag |
| smp_valid_i | input | 1 | Sample strobe |
| smp_left_i | input | 24 | Left sample |
| smp_right_i | input | 24 | Right sample |
| rd_pop_i | input | 1 | Pop the oldest word |
| rd_data_o | output | 32 | Oldest word |
| level_o | output | 8 | Words stored |
| not_empty_o | output | 1 | Store not empty |
| thr_irq_o | output | 1 | Threshold interrupt |
| thr_wake_o | output | 1 | Threshold wake request |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Combined interrupt |
| dreq_dflt_o | output | 1 | Threshold event on the default DMA request line |
| dreq_fifo_o | output | 1 | Threshold event on the FIFO DMA request line |

## Verification
A wrong pointer or count inside the store shows at `rd_data_o` or `level_o` in the cycle after the faulty write or pop. A stale half word in the packer shows only later, as a swapped or foreign half in the next mono 16-bit word, so the bench reads back whole packed words after mode changes and after flushes. The threshold and overrun outputs are decoded straight from the count and the sticky flag. A fault in the code-to-count mapping therefore shows exactly one word before or after the expected level, and the bench samples that level from both sides.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
    localparam int WORD_W = 32;
    localparam int SMP_W  = 24;
    localparam int HALF_W = 16;
    localparam int THR_W  = 6;
    localparam int NEN    = 4;

    typedef enum logic [1:0] {
        PK_MONO16   = 2'd0,
        PK_STEREO16 = 2'd1,
        PK_MONO24   = 2'd2,
        PK_STEREO24 = 2'd3
    } pack_mode_e;

    localparam int EN_NE   = 0;
    localparam int EN_THR  = 1;
    localparam int EN_WAKE = 2;
    localparam int EN_OVR  = 3;
endpackage

// File: rtl/cpf_packer.sv
module cpf_packer
    import cpf_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int WW = WORD_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          valid_i,
    input  pack_mode_e    mode_i,
    input  logic [SW-1:0] left_i,
    input  logic [SW-1:0] right_i,
    output logic [1:0]    n_push_o,
    output logic [WW-1:0] w0_o,
    output logic [WW-1:0] w1_o
);
    typedef struct packed {
        logic          hv;
        logic [HW-1:0] hd;
    } pk_state_t;

    pk_state_t st_q, st_d;

    function automatic logic [WW-1:0] sext(input logic [SW-1:0] s);
        return {{(WW-SW){s[SW-1]}}, s};
    endfunction

    always_comb begin
        st_d     = st_q;
        n_push_o = 2'd0;
        w0_o     = '0;
        w1_o     = '0;
        if (flush_i) begin
            st_d.hv = 1'b0;
        end else begin
            if (mode_i != PK_MONO16) st_d.hv = 1'b0;
            if (valid_i) begin
                case (mode_i)
                    PK_MONO16: begin
                        if (st_q.hv) begin
                            n_push_o = 2'd1;
                            w0_o     = {left_i[HW-1:0], st_q.hd};
                            st_d.hv  = 1'b0;
                        end else begin
                            st_d.hv = 1'b1;
                            st_d.hd = left_i[HW-1:0];
                        end
                    end
                    PK_STEREO16: begin
                        n_push_o = 2'd1;
                        w0_o     = {right_i[HW-1:0], left_i[HW-1:0]};
                    end
                    PK_MONO24: begin
                        n_push_o = 2'd1;
                        w0_o     = sext(left_i);
                    end
                    default: begin
                        n_push_o = 2'd2;
                        w0_o     = sext(left_i);
                        w1_o     = sext(right_i);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_MONO16_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PK_MONO16 && valid_i && !flush_i && !st_q.hv) |-> n_push_o == 2'd0); // R2
    AST_STEREO24_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PK_STEREO24 && valid_i && !flush_i) |-> n_push_o == 2'd2); // R5
    AST_FLUSH_DROPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !st_q.hv); // R11
endmodule

// File: rtl/cpf_store.sv
module cpf_store
    import cpf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WW    = WORD_W,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [1:0]    n_push_i,
    input  logic [WW-1:0] w0_i,
    input  logic [WW-1:0] w1_i,
    input  logic          pop_i,
    output logic [WW-1:0] rd_data_o,
    output logic [CW-1:0] count_o,
    output logic          drop_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_state_t;

    st_state_t st_q, st_d;
    logic [WW-1:0] mem [DEPTH];
    logic [CW-1:0] space;
    logic acc0, acc1, pop_ok;

    always_comb begin
        space  = CW'(DEPTH) - st_q.cnt;
        acc0   = !flush_i && (n_push_i >= 2'd1) && (space != '0);
        acc1   = !flush_i && (n_push_i == 2'd2) && (space >= CW'(2));
        drop_o = !flush_i && (((n_push_i >= 2'd1) && (space == '0)) ||
                              ((n_push_i == 2'd2) && (space < CW'(2))));
        pop_ok = !flush_i && pop_i && (st_q.cnt != '0);
        st_d   = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            st_d.wr  = st_q.wr + AW'(acc0) + AW'(acc1);
            st_d.rd  = st_q.rd + AW'(pop_ok);
            st_d.cnt = st_q.cnt + CW'(acc0) + CW'(acc1) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (acc0) mem[st_q.wr] <= w0_i;
        if (acc1) mem[st_q.wr + AW'(1)] <= w1_i;
    end

    assign rd_data_o = mem[st_q.rd];
    assign count_o   = st_q.cnt;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(DEPTH) && !pop_i && !flush_i) |=> st_q.cnt == CW'(DEPTH)); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && n_push_i == 2'd0) |=> st_q.cnt == '0); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> st_q.cnt == '0); // R1
endmodule

// File: rtl/cpf_events.sv
module cpf_events
    import cpf_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = THR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush_i,
    input  logic [CW-1:0]  count_i,
    input  logic [TW-1:0]  thr_code_i,
    input  logic [NEN-1:0] ien_i,
    input  logic           dreq_sel_i,
    input  logic           drop_i,
    input  logic           ovr_clr_i,
    output logic           not_empty_o,
    output logic           thr_irq_o,
    output logic           thr_wake_o,
    output logic           ovr_o,
    output logic           irq_o,
    output logic           dreq_dflt_o,
    output logic           dreq_fifo_o
);
    typedef struct packed {
        logic ovr;
    } ev_state_t;

    ev_state_t st_q, st_d;
    logic [CW-1:0] thr_words;
    logic thr_hit;

    always_comb begin
        thr_words = (thr_code_i == '0) ? CW'(1) : CW'({thr_code_i, 1'b0});
        thr_hit   = count_i >= thr_words;
        st_d      = st_q;
        if (flush_i)        st_d.ovr = 1'b0;
        else if (drop_i)    st_d.ovr = 1'b1;
        else if (ovr_clr_i) st_d.ovr = 1'b0;
        not_empty_o = count_i != '0;
        ovr_o       = st_q.ovr;
        thr_irq_o   = thr_hit & ien_i[EN_THR];
        thr_wake_o  = thr_hit & ien_i[EN_WAKE];
        irq_o       = (not_empty_o & ien_i[EN_NE]) | thr_irq_o | (st_q.ovr & ien_i[EN_OVR]);
        dreq_dflt_o = thr_hit & !dreq_sel_i;
        dreq_fifo_o = thr_hit & dreq_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !ovr_clr_i && !flush_i) |=> st_q.ovr); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ien_i != '0); // R10
    AST_DREQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_dflt_o || dreq_fifo_o) |-> not_empty_o); // R8
    AST_DREQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dreq_dflt_o, dreq_fifo_o})); // R8
endmodule

// File: rtl/cap_pack_fifo.sv
module cap_pack_fifo
    import cpf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [1:0]        mode_i,
    input  logic [THR_W-1:0]  thr_code_i,
    input  logic [NEN-1:0]    ien_i,
    input  logic              dreq_sel_i,
    input  logic              ovr_clr_i,
    input  logic              smp_valid_i,
    input  logic [SMP_W-1:0]  smp_left_i,
    input  logic [SMP_W-1:0]  smp_right_i,
    input  logic              rd_pop_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [LW-1:0]     level_o,
    output logic              not_empty_o,
    output logic              thr_irq_o,
    output logic              thr_wake_o,
    output logic              ovr_o,
    output logic              irq_o,
    output logic              dreq_dflt_o,
    output logic              dreq_fifo_o
);
    logic              flush;
    logic [1:0]        n_push;
    logic [WORD_W-1:0] w0, w1;
    logic              drop;

    assign flush = !run_i;

    cpf_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush),
        .valid_i  (smp_valid_i),
        .mode_i   (pack_mode_e'(mode_i)),
        .left_i   (smp_left_i),
        .right_i  (smp_right_i),
        .n_push_o (n_push),
        .w0_o     (w0),
        .w1_o     (w1)
    );

    cpf_store #(.DEPTH(DEPTH), .CW(LW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .n_push_i  (n_push),
        .w0_i      (w0),
        .w1_i      (w1),
        .pop_i     (rd_pop_i),
        .rd_data_o (rd_data_o),
        .count_o   (level_o),
        .drop_o    (drop)
    );

    cpf_events #(.CW(LW)) u_ev (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .count_i     (level_o),
        .thr_code_i  (thr_code_i),
        .ien_i       (ien_i),
        .dreq_sel_i  (dreq_sel_i),
        .drop_i      (drop),
        .ovr_clr_i   (ovr_clr_i),
        .not_empty_o (not_empty_o),
        .thr_irq_o   (thr_irq_o),
        .thr_wake_o  (thr_wake_o),
        .ovr_o       (ovr_o),
        .irq_o       (irq_o),
        .dreq_dflt_o (dreq_dflt_o),
        .dreq_fifo_o (dreq_fifo_o)
    );
endmodule

// File: tb/tb_cap_pack_fifo.sv
`timescale 1ns/1ps
module tb_cap_pack_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [5:0]  thr_code_i = 6'd0;
    logic [3:0]  ien_i = 4'd0;
    logic        dreq_sel_i = 1'b0;
    logic        ovr_clr_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [23:0] smp_left_i = '0;
    logic [23:0] smp_right_i = '0;
    logic        rd_pop_i = 1'b0;
    logic [31:0] rd_data_o;
    logic [7:0]  level_o;
    logic        not_empty_o, thr_irq_o, thr_wake_o, ovr_o, irq_o, dreq_dflt_o, dreq_fifo_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cap_pack_fifo dut (.*);

    typedef struct packed {
        logic [1:0]  md;
        logic [23:0] la, ra, lb, rb;
        logic [2:0]  n;
        logic [31:0] e0, e1, e2, e3;
    } vec_t;

    localparam vec_t VT [5] = '{
        '{2'd0, 24'hFF1234, 24'h005555, 24'h00ABCD, 24'h00AAAA, 3'd1,
          32'hABCD1234, 32'h0, 32'h0, 32'h0},
        '{2'd0, 24'h00FFFF, 24'h000000, 24'h000001, 24'h000000, 3'd1,
          32'h0001FFFF, 32'h0, 32'h0, 32'h0},
        '{2'd1, 24'h001111, 24'h002222, 24'h993333, 24'h008444, 3'd2,
          32'h22221111, 32'h84443333, 32'h0, 32'h0},
        '{2'd2, 24'h800001, 24'h123456, 24'h7FFFFF, 24'h000000, 3'd2,
          32'hFF800001, 32'h007FFFFF, 32'h0, 32'h0},
        '{2'd3, 24'h123456, 24'hFEDCBA, 24'h800000, 24'h000001, 3'd4,
          32'h00123456, 32'hFFFEDCBA, 32'hFF800000, 32'h00000001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r);
        smp_valid_i = 1'b1; smp_left_i = l; smp_right_i = r;
        @(negedge clk);
        smp_valid_i = 1'b0;
    endtask

    task automatic pop();
        rd_pop_i = 1'b1;
        @(negedge clk);
        rd_pop_i = 1'b0;
    endtask

    task automatic restart();
        run_i = 1'b0;
        @(negedge clk);
        run_i = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and samples ignored while held
        chk("R1 level after reset", 32'(level_o), 32'd0);
        chk("R1 not_empty after reset", 32'(not_empty_o), 32'd0);
        mode_i = 2'd2;
        push(24'h000077, 24'h0);
        chk("R1 sample ignored while held", 32'(level_o), 32'd0);

        // packing table
        for (int i = 0; i < 5; i++) begin
            string tag;
            logic [31:0] ex [4];
            tag = (VT[i].md == 2'd0) ? "R2" : (VT[i].md == 2'd1) ? "R3" :
                  (VT[i].md == 2'd2) ? "R4" : "R5";
            ex[0] = VT[i].e0; ex[1] = VT[i].e1; ex[2] = VT[i].e2; ex[3] = VT[i].e3;
            mode_i = VT[i].md;
            restart();
            push(VT[i].la, VT[i].ra);
            push(VT[i].lb, VT[i].rb);
            chk({tag, " word count"}, 32'(level_o), 32'(VT[i].n));
            for (int k = 0; k < int'(VT[i].n); k++) begin
                chk({tag, " packed word"}, rd_data_o, ex[k]);
                pop();
            end
            chk("R6 drained", 32'(level_o), 32'd0);
        end

        // R6: pop on empty ignored, order kept
        mode_i = 2'd2;
        restart();
        pop();
        chk("R6 pop on empty", 32'(level_o), 32'd0);
        push(24'h000005, 24'h0);
        push(24'h000006, 24'h0);
        chk("R6 oldest first", rd_data_o, 32'h5);
        pop();
        chk("R6 second word", rd_data_o, 32'h6);

        // R11: half word discarded by run low
        mode_i = 2'd0;
        restart();
        push(24'h00DEAD, 24'h0);
        chk("R2 half word waits", 32'(level_o), 32'd0);
        restart();
        push(24'h000111, 24'h0);
        push(24'h000222, 24'h0);
        chk("R11 stale half dropped", rd_data_o, 32'h02220111);

        // R10: enables gate irq
        ien_i = 4'b0000;
        #1 chk("R10 irq masked", 32'(irq_o), 32'd0);
        ien_i = 4'b0001;
        #1 chk("R10 irq from not_empty", 32'(irq_o), 32'd1);
        @(negedge clk);

        // R7/R8: code 0 is one word
        mode_i = 2'd2; thr_code_i = 6'd0; ien_i = 4'b0110;
        restart();
        chk("R7 code0 below", 32'(thr_irq_o), 32'd0);
        push(24'h1, 24'h0);
        chk("R7 code0 one word", 32'(thr_irq_o), 32'd1);
        chk("R8 wake", 32'(thr_wake_o), 32'd1);

        // code 48 = 96 words, fill to overrun
        thr_code_i = 6'd48; ien_i = 4'b1000; dreq_sel_i = 1'b0;
        restart();
        for (int i = 0; i < 128; i++) begin
            push(24'(i), 24'h0);
            if (i == 94) chk("R7 95 words below", 32'(dreq_dflt_o), 32'd0);
            if (i == 95) chk("R7 96 words reached", 32'(dreq_dflt_o), 32'd1);
        end
        chk("R8 interrupt masked", 32'(thr_irq_o), 32'd0);
        chk("R8 fifo line idle", 32'(dreq_fifo_o), 32'd0);
        dreq_sel_i = 1'b1;
        #1 chk("R8 routed to fifo line", 32'(dreq_fifo_o), 32'd1);
        chk("R8 default line idle", 32'(dreq_dflt_o), 32'd0);
        @(negedge clk);
        chk("R9 no overrun at full", 32'(ovr_o), 32'd0);
        push(24'h0000FF, 24'h0);
        chk("R9 level stays full", 32'(level_o), 32'd128);
        chk("R9 overrun set", 32'(ovr_o), 32'd1);
        chk("R10 irq from overrun", 32'(irq_o), 32'd1);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) begin
                if (rd_data_o !== 32'(i)) bad++;
                pop();
            end
            chk("R9 stored words intact", 32'(bad), 32'd0);
        end
        chk("R9 sticky after drain", 32'(ovr_o), 32'd1);
        ovr_clr_i = 1'b1;
        @(negedge clk);
        ovr_clr_i = 1'b0;
        chk("R9 cleared by pulse", 32'(ovr_o), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule